// File: doc/BRIEF.md
# Single-Wire ROM Command Layer

This block is the network layer of a single-wire slave that owns a 64-bit identifier. The identifier is built from an 8-bit family code and a 48-bit serial number, both given at ports, plus an 8-bit check byte that the block computes itself. A bit-level engine sits below the block. It reports each reset-and-presence cycle, each bit the master writes, and each read slot in which it sent the bit the block offered. After every line reset the block collects an 8-bit ROM command. It then runs one of these: the identifier dump, the addressed select, the binary-tree search, the unaddressed select, or the resume shortcut. At the end it either hands the bus to the function layer or drops out until the next line reset.

The block keeps a resume flag. Only a successful addressed select or a successful search sets it. The dump, the unaddressed select, and any addressed select or search that fails for this device clear it. The resume shortcut selects the device again only while the flag is set.

States:
- `ST_WAIT`: passive, waiting for a line reset.
- `ST_CMD`: receiving the command byte.
- `ST_READ`: sending the identifier.
- `ST_MATCH`: comparing the received identifier.
- `ST_SRCH_TRUE`, `ST_SRCH_CMP`, `ST_SRCH_DIR`: the three slots of one search step.
- `ST_FUNC`: the function layer owns the bus.

Transitions:
- A line reset moves every state to `ST_CMD`.
- `ST_CMD` branches on the decoded code. The search code goes to `ST_SRCH_TRUE`, the dump code to `ST_READ` and the select code to `ST_MATCH`. The skip code goes to `ST_FUNC`. The resume code goes to `ST_FUNC` when the flag is set and to `ST_WAIT` when it is not. Any other code goes to `ST_WAIT`.
- `ST_READ` goes to `ST_FUNC` after 64 bits.
- `ST_MATCH` goes to `ST_FUNC` after 64 equal bits, and to `ST_WAIT` on the first unequal bit.
- The search cycles `ST_SRCH_TRUE` → `ST_SRCH_CMP` → `ST_SRCH_DIR`, then back to `ST_SRCH_TRUE` for the next bit. After the last bit it goes to `ST_FUNC`. On a direction that differs from the device's bit it goes to `ST_WAIT`.

Top module: `swr_rom_layer`

## Requirements
- R1: After `rst_n` is released, the block waits for a line reset. `tx_pend`, `fn_active` and `resume_flag` are 0, and received bits have no effect before the first `line_reset`.
- R2: After `line_reset`, the next 8 received bits form the command, least significant bit first. The codes are F0h search, 33h dump, 55h addressed select, CCh unaddressed select and A5h resume. Bits received while in `ST_FUNC` are ignored.
- R3: The dump offers 64 bits on `tx_bit`, least significant first, one bit per `tx_done`. Bits 0–7 are the family code, bits 8–55 the serial number and bits 56–63 the check byte. After the last bit, `fn_active` is 1 and `resume_flag` is 0.
- R4: The check byte is the CRC with polynomial x^8+x^5+x^4+1 over identifier bits 0–55. It starts from zero and is shifted least significant bit first.
- R5: An addressed select whose 64 received bits all equal the identifier sets `resume_flag` and `fn_active`.
- R6: At the first received bit that differs, an addressed select clears `resume_flag` and enters `ST_WAIT`. Later bits are ignored.
- R7: Search offers, for each bit from bit 0 upward, the identifier bit, then its complement, then receives the master's direction bit.
- R8: A search whose 64 direction bits all equal the identifier sets `resume_flag` and `fn_active`.
- R9: A direction bit that differs from the identifier bit clears `resume_flag`. The block then enters `ST_WAIT` with `tx_pend` at 0.
- R10: The unaddressed select sets `fn_active` right after the command byte and clears `resume_flag`.
- R11: Resume sets `fn_active` and keeps `resume_flag` when the flag is 1. Otherwise it enters `ST_WAIT` with `fn_active` at 0.
- R12: An undefined command code enters `ST_WAIT` and leaves `resume_flag` unchanged.
- R13: A `line_reset` in any state aborts the command in progress and restarts command reception. `resume_flag` keeps its value through the abort.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_reset | input | 1 | One-cycle pulse when a reset/presence cycle is complete |
| rx_valid | input | 1 | One-cycle pulse when the master has written a bit |
| rx_bit | input | 1 | The bit the master wrote |
| tx_done | input | 1 | One-cycle pulse when a read slot has carried `tx_bit` |
| family_code | input | FAM_W | Family code, identifier bits 0 upward |
| serial_num | input | SER_W | Serial number, after the family code |
| tx_pend | output | 1 | A bit is offered for the next read slot |
| tx_bit | output | 1 | The offered bit |
| fn_active | output | 1 | The function layer owns the bus |
| resume_flag | output | 1 | Resume flag state |

## Verification
The assertions assume a well-behaved bit engine:
- `rx_valid`, `tx_done` and `line_reset` are single-cycle pulses.
- `tx_done` comes only while `tx_pend` is high.
- The identifier ports stay steady within a transaction.

The stimulus meets these by issuing each slot through tasks that raise one pulse for one cycle, by never raising `tx_done` outside a transmit phase, and by changing the identifier only between transactions. Random commands, mismatch positions, drop-out positions and abort points are drawn from a fixed seed. They are mixed with directed cases at bit 0, bit 63 and the flag-dependent resume paths.

// File: rtl/swr_pkg.sv
package swr_pkg;

    localparam int CMD_W = 8;

    localparam logic [CMD_W-1:0] OP_SEARCH = 8'hF0;
    localparam logic [CMD_W-1:0] OP_READ   = 8'h33;
    localparam logic [CMD_W-1:0] OP_MATCH  = 8'h55;
    localparam logic [CMD_W-1:0] OP_SKIP   = 8'hCC;
    localparam logic [CMD_W-1:0] OP_RESUME = 8'hA5;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_CMD,
        ST_READ,
        ST_MATCH,
        ST_SRCH_TRUE,
        ST_SRCH_CMP,
        ST_SRCH_DIR,
        ST_FUNC
    } swr_state_e;

    typedef enum logic [2:0] {
        RC_NONE,
        RC_SEARCH,
        RC_READ,
        RC_MATCH,
        RC_SKIP,
        RC_RESUME
    } swr_rom_cmd_e;

endpackage

// File: rtl/swr_id_crc.sv
// Bit-serial CRC unrolled over the identifier payload, LSB first, zero seed.
module swr_id_crc #(
    parameter int DATA_W = 56,
    parameter int CRC_W  = 8,
    parameter logic [CRC_W-1:0] POLY_REFL = 8'h8C
) (
    input  logic [DATA_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_out
);

    logic [CRC_W-1:0] chain [DATA_W+1];

    assign chain[0] = '0;

    for (genvar g = 0; g < DATA_W; g++) begin : g_stage
        logic fb;
        assign fb = chain[g][0] ^ data_in[g];
        assign chain[g+1] = (chain[g] >> 1) ^ (fb ? POLY_REFL : '0);
    end

    assign crc_out = chain[DATA_W];

endmodule

// File: rtl/swr_cmd_decode.sv
// Maps a received command byte to the internal command kind.
module swr_cmd_decode
    import swr_pkg::*;
(
    input  logic [CMD_W-1:0] code,
    output swr_rom_cmd_e     kind
);

    always_comb begin
        case (code)
            OP_SEARCH: kind = RC_SEARCH;
            OP_READ:   kind = RC_READ;
            OP_MATCH:  kind = RC_MATCH;
            OP_SKIP:   kind = RC_SKIP;
            OP_RESUME: kind = RC_RESUME;
            default:   kind = RC_NONE;
        endcase
    end

endmodule

// File: rtl/swr_id_select.sv
// Assembles the identifier and selects the bit at the current index.
module swr_id_select #(
    parameter int FAM_W = 8,
    parameter int SER_W = 48,
    parameter int CRC_W = 8,
    localparam int ID_W  = FAM_W + SER_W + CRC_W,
    localparam int IDX_W = $clog2(ID_W)
) (
    input  logic [FAM_W-1:0] family_code,
    input  logic [SER_W-1:0] serial_num,
    input  logic [CRC_W-1:0] crc_byte,
    input  logic [IDX_W-1:0] idx,
    output logic             id_bit
);

    logic [ID_W-1:0] id_vec;

    assign id_vec = {crc_byte, serial_num, family_code};
    assign id_bit = id_vec[idx];

endmodule

// File: rtl/swr_rom_layer.sv
// ROM command layer: command decode, identifier dump/compare/search, resume flag.
module swr_rom_layer
    import swr_pkg::*;
#(
    parameter int FAM_W = 8,
    parameter int SER_W = 48,
    parameter int CRC_W = 8,
    parameter logic [CRC_W-1:0] CRC_POLY = 8'h8C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_reset,
    input  logic             rx_valid,
    input  logic             rx_bit,
    input  logic             tx_done,
    input  logic [FAM_W-1:0] family_code,
    input  logic [SER_W-1:0] serial_num,
    output logic             tx_pend,
    output logic             tx_bit,
    output logic             fn_active,
    output logic             resume_flag
);

    localparam int DATA_W = FAM_W + SER_W;
    localparam int ID_W   = DATA_W + CRC_W;
    localparam int IDX_W  = $clog2(ID_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ID_W - 1);
    localparam logic [IDX_W-1:0] CMD_LAST = IDX_W'(CMD_W - 1);

    swr_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [CMD_W-1:0] cmd_q, cmd_d;
    logic             flag_q, flag_d;

    logic [CMD_W-1:0] cmd_full;
    swr_rom_cmd_e     cmd_kind;
    logic [CRC_W-1:0] crc_byte;
    logic             id_bit;
    logic             id_last;
    logic             cmd_last;

    swr_id_crc #(
        .DATA_W   (DATA_W),
        .CRC_W    (CRC_W),
        .POLY_REFL(CRC_POLY)
    ) crc_i (
        .data_in({serial_num, family_code}),
        .crc_out(crc_byte)
    );

    assign cmd_full = {rx_bit, cmd_q[CMD_W-1:1]};

    swr_cmd_decode dec_i (
        .code(cmd_full),
        .kind(cmd_kind)
    );

    swr_id_select #(
        .FAM_W(FAM_W),
        .SER_W(SER_W),
        .CRC_W(CRC_W)
    ) sel_i (
        .family_code(family_code),
        .serial_num (serial_num),
        .crc_byte   (crc_byte),
        .idx        (idx_q),
        .id_bit     (id_bit)
    );

    assign id_last  = (idx_q == LAST_IDX);
    assign cmd_last = (idx_q == CMD_LAST);

    // Next-state and datapath
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        cmd_d   = cmd_q;
        flag_d  = flag_q;
        if (line_reset) begin
            state_d = ST_CMD;
            idx_d   = '0;
            cmd_d   = '0;
        end else begin
            unique case (state_q)
                ST_WAIT, ST_FUNC: begin
                end
                ST_CMD: begin
                    if (rx_valid) begin
                        cmd_d = cmd_full;
                        idx_d = idx_q + 1'b1;
                        if (cmd_last) begin
                            idx_d = '0;
                            case (cmd_kind)
                                RC_SEARCH: state_d = ST_SRCH_TRUE;
                                RC_READ:   state_d = ST_READ;
                                RC_MATCH:  state_d = ST_MATCH;
                                RC_SKIP: begin
                                    flag_d  = 1'b0;
                                    state_d = ST_FUNC;
                                end
                                RC_RESUME: state_d = flag_q ? ST_FUNC : ST_WAIT;
                                default:   state_d = ST_WAIT;
                            endcase
                        end
                    end
                end
                ST_READ: begin
                    if (tx_done) begin
                        if (id_last) begin
                            flag_d  = 1'b0;
                            state_d = ST_FUNC;
                        end else begin
                            idx_d = idx_q + 1'b1;
                        end
                    end
                end
                ST_MATCH: begin
                    if (rx_valid) begin
                        if (rx_bit != id_bit) begin
                            flag_d  = 1'b0;
                            state_d = ST_WAIT;
                        end else if (id_last) begin
                            flag_d  = 1'b1;
                            state_d = ST_FUNC;
                        end else begin
                            idx_d = idx_q + 1'b1;
                        end
                    end
                end
                ST_SRCH_TRUE: begin
                    if (tx_done) state_d = ST_SRCH_CMP;
                end
                ST_SRCH_CMP: begin
                    if (tx_done) state_d = ST_SRCH_DIR;
                end
                ST_SRCH_DIR: begin
                    if (rx_valid) begin
                        if (rx_bit != id_bit) begin
                            flag_d  = 1'b0;
                            state_d = ST_WAIT;
                        end else if (id_last) begin
                            flag_d  = 1'b1;
                            state_d = ST_FUNC;
                        end else begin
                            idx_d   = idx_q + 1'b1;
                            state_d = ST_SRCH_TRUE;
                        end
                    end
                end
                default: state_d = ST_WAIT;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            idx_q   <= '0;
            cmd_q   <= '0;
            flag_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            cmd_q   <= cmd_d;
            flag_q  <= flag_d;
        end
    end

    // Outputs
    always_comb begin
        tx_pend     = 1'b0;
        tx_bit      = 1'b1;
        fn_active   = 1'b0;
        resume_flag = flag_q;
        unique case (state_q)
            ST_READ, ST_SRCH_TRUE: begin
                tx_pend = 1'b1;
                tx_bit  = id_bit;
            end
            ST_SRCH_CMP: begin
                tx_pend = 1'b1;
                tx_bit  = ~id_bit;
            end
            ST_FUNC: fn_active = 1'b1;
            default: begin
            end
        endcase
    end

    // Assertions
    assert_abort_restarts_R13: assert property (@(posedge clk) disable iff (!rst_n)
        line_reset |=> (!tx_pend && !fn_active && resume_flag == $past(resume_flag)));

    assert_flag_set_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resume_flag) |-> ($past(state_q) == ST_MATCH || $past(state_q) == ST_SRCH_DIR));

    assert_flag_clear_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(resume_flag) |-> ($past(state_q) == ST_CMD || $past(state_q) == ST_READ ||
                                $past(state_q) == ST_MATCH || $past(state_q) == ST_SRCH_DIR));

    assert_select_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fn_active) |-> ($past(state_q) == ST_CMD || $past(state_q) == ST_READ ||
                              $past(state_q) == ST_MATCH || $past(state_q) == ST_SRCH_DIR));

    assert_complement_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SRCH_CMP && $past(state_q) == ST_SRCH_TRUE) |-> (tx_bit != $past(tx_bit)));

    assert_wait_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !line_reset) |=> (state_q == ST_WAIT && !tx_pend && !fn_active));

endmodule

// File: tb/swr_rom_layer_tb_top.sv
module swr_rom_layer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int FAM_W = 8;
    localparam int SER_W = 48;
    localparam int CRC_W = 8;
    localparam int ID_W  = FAM_W + SER_W + CRC_W;

    logic clk, rst_n, line_reset, rx_valid, rx_bit, tx_done;
    logic [FAM_W-1:0] family_code;
    logic [SER_W-1:0] serial_num;
    logic tx_pend, tx_bit, fn_active, resume_flag;

    int checks = 0;
    int fails  = 0;
    logic exp_flag;

    swr_rom_layer dut_i (
        .clk(clk), .rst_n(rst_n), .line_reset(line_reset),
        .rx_valid(rx_valid), .rx_bit(rx_bit), .tx_done(tx_done),
        .family_code(family_code), .serial_num(serial_num),
        .tx_pend(tx_pend), .tx_bit(tx_bit),
        .fn_active(fn_active), .resume_flag(resume_flag)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    function automatic logic [7:0] bench_crc(input logic [55:0] d);
        logic [7:0] c;
        logic fb;
        c = 8'h00;
        for (int i = 0; i < 56; i++) begin
            fb = c[0] ^ d[i];
            c = {fb, c[7:1]};
            c[3] = c[3] ^ fb;
            c[2] = c[2] ^ fb;
        end
        return c;
    endfunction

    function automatic logic [63:0] bench_id();
        return {bench_crc({serial_num, family_code}), serial_num, family_code};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_reset();
        @(negedge clk) line_reset = 1'b1;
        @(negedge clk) line_reset = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_bit   = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic send_cmd(input logic [7:0] c);
        for (int i = 0; i < 8; i++) send_bit(c[i]);
    endtask

    task automatic take_bit(output logic b, output logic p);
        @(negedge clk);
        p = tx_pend;
        b = tx_bit;
        if (p) tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
    endtask

    task automatic do_read(input string tag);
        logic [63:0] got;
        logic b, p, allp;
        allp = 1'b1;
        got = '0;
        pulse_reset();
        send_cmd(8'h33);
        for (int i = 0; i < ID_W; i++) begin
            take_bit(b, p);
            got[i] = b;
            allp = allp & p;
        end
        @(negedge clk);
        chk({tag, " R3 dump bits"}, got, bench_id());
        chk({tag, " R4 check byte"}, {56'd0, got[63:56]}, {56'd0, bench_crc({serial_num, family_code})});
        chk({tag, " R3 tx_pend each slot"}, {63'd0, allp}, 64'd1);
        exp_flag = 1'b0;
        chk({tag, " R3 selected, flag cleared"}, {62'd0, fn_active, resume_flag}, {62'd0, 1'b1, exp_flag});
    endtask

    // bad_at < 0: every bit matches
    task automatic do_match(input int bad_at, input string tag);
        logic [63:0] id;
        id = bench_id();
        pulse_reset();
        send_cmd(8'h55);
        for (int i = 0; i < ID_W; i++) send_bit((i == bad_at) ? ~id[i] : id[i]);
        @(negedge clk);
        if (bad_at < 0) begin
            exp_flag = 1'b1;
            chk({tag, " R5 match selects"}, {62'd0, fn_active, resume_flag}, {62'd0, 2'b11});
        end else begin
            exp_flag = 1'b0;
            chk({tag, " R6 mismatch drops"}, {61'd0, fn_active, resume_flag, tx_pend}, 64'd0);
        end
    endtask

    task automatic do_search(input int drop_at, input string tag);
        logic [63:0] id;
        logic t, c, p1, p2, ok;
        id = bench_id();
        ok = 1'b1;
        pulse_reset();
        send_cmd(8'hF0);
        for (int i = 0; i < ID_W; i++) begin
            take_bit(t, p1);
            take_bit(c, p2);
            if (!(p1 && p2 && t == id[i] && c == ~id[i])) ok = 1'b0;
            send_bit((i == drop_at) ? ~id[i] : id[i]);
            if (i == drop_at) break;
        end
        @(negedge clk);
        chk({tag, " R7 triplet values"}, {63'd0, ok}, 64'd1);
        if (drop_at < 0) begin
            exp_flag = 1'b1;
            chk({tag, " R8 search selects"}, {62'd0, fn_active, resume_flag}, {62'd0, 2'b11});
        end else begin
            exp_flag = 1'b0;
            chk({tag, " R9 search drop-out"}, {61'd0, fn_active, resume_flag, tx_pend}, 64'd0);
        end
    endtask

    task automatic do_skip(input string tag);
        pulse_reset();
        send_cmd(8'hCC);
        @(negedge clk);
        exp_flag = 1'b0;
        chk({tag, " R10 skip selects"}, {62'd0, fn_active, resume_flag}, {62'd0, 2'b10});
    endtask

    task automatic do_resume(input string tag);
        pulse_reset();
        send_cmd(8'hA5);
        @(negedge clk);
        chk({tag, " R11 resume"}, {61'd0, fn_active, resume_flag, tx_pend}, {61'd0, exp_flag, exp_flag, 1'b0});
    endtask

    task automatic do_unknown(input logic [7:0] code, input string tag);
        pulse_reset();
        send_cmd(code);
        send_bit(1'b0);
        send_bit(1'b1);
        @(negedge clk);
        chk({tag, " R12 undefined code"}, {61'd0, fn_active, resume_flag, tx_pend}, {61'd0, 1'b0, exp_flag, 1'b0});
    endtask

    task automatic do_abort(input int nbits, input string tag);
        logic [63:0] id;
        id = bench_id();
        pulse_reset();
        send_cmd(8'h55);
        for (int i = 0; i < nbits; i++) send_bit(id[i]);
        pulse_reset();
        @(negedge clk);
        chk({tag, " R13 abort keeps flag"}, {61'd0, fn_active, resume_flag, tx_pend}, {61'd0, 1'b0, exp_flag, 1'b0});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired R1 actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] ucode;
        int op;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; line_reset = 1'b0; rx_valid = 1'b0; rx_bit = 1'b0; tx_done = 1'b0;
        family_code = 8'h28;
        serial_num  = 48'h0000_0A1B_2C3D;
        exp_flag = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset outputs", {61'd0, tx_pend, fn_active, resume_flag}, 64'd0);
        send_cmd(8'hCC);
        @(negedge clk);
        chk("R1 bits before line reset ignored", {61'd0, tx_pend, fn_active, resume_flag}, 64'd0);

        do_read("directed");
        do_match(-1, "directed");
        do_resume("directed flag set");
        do_skip("directed");
        send_cmd(8'h33);
        @(negedge clk);
        chk("R2 bits ignored while selected", {62'd0, fn_active, tx_pend}, {62'd0, 2'b10});
        do_resume("directed flag clear");
        do_match(-1, "directed");
        do_match(63, "directed bit63");
        do_match(-1, "directed");
        do_match(0, "directed bit0");
        do_search(-1, "directed");
        do_search(0, "directed bit0");
        do_search(-1, "directed");
        do_search(63, "directed bit63");
        do_match(-1, "directed");
        do_unknown(8'h0F, "directed");
        do_abort(20, "directed");
        do_skip("directed after abort");

        family_code = 8'hFF;
        serial_num  = '1;
        do_read("all ones");
        family_code = 8'h00;
        serial_num  = '0;
        do_read("all zeros");

        for (int n = 0; n < 110; n++) begin
            if ($urandom_range(0, 3) == 0) begin
                family_code = 8'($urandom);
                serial_num  = {16'($urandom), 32'($urandom)};
            end
            op = int'($urandom_range(0, 6));
            case (op)
                0: do_read("random");
                1: do_match(($urandom_range(0, 1) == 0) ? -1 : int'($urandom_range(0, 63)), "random");
                2: do_search(($urandom_range(0, 1) == 0) ? -1 : int'($urandom_range(0, 63)), "random");
                3: do_skip("random");
                4: do_resume("random");
                5: begin
                    ucode = 8'($urandom);
                    while (ucode == 8'hF0 || ucode == 8'h33 || ucode == 8'h55 ||
                           ucode == 8'hCC || ucode == 8'hA5) ucode = 8'($urandom);
                    do_unknown(ucode, "random");
                end
                default: do_abort(int'($urandom_range(1, 63)), "random");
            endcase
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule